// File: doc/BRIEF.md
# Shared-Bus Accumulator Datapath

This block is the register-and-bus half of a small accumulator machine. Seven storage registers hang on one 16-bit bus: a 12-bit operand address register, a 12-bit program counter, a data register, an accumulator, an instruction register, a scratch register and an output register. An 8-bit input register and a one-bit carry flag sit beside the bus. Each cycle a 3-bit select code names the one source that drives the bus. The eighth code makes the bus carry read data from memory. At the rising edge, any register whose strobes are raised updates from the bus, clears or counts up.

The accumulator never loads straight from the bus. Its load strobe writes the output of an arithmetic/logic unit. That unit combines the accumulator with the data register or the input register. On an addition the carry out lands in the flag. Memory is outside the block: read data comes in on a port, write data is the bus itself, and the address is the address register. A separate sequencer, not part of this block, drives every select, strobe and operation code.

Top module: `acc_bus_datapath`

## Requirements
- R1: `sel_i` picks the bus source: 0 gives all zeros, 1 the address register, 2 the program counter, 3 the data register, 4 the accumulator, 5 the instruction register, 6 the scratch register, 7 `mem_rdata_i`.
- R2: When the address register or the program counter drives the bus, its 12 bits appear zero-extended to 16. When either one loads, it takes bits 11..0 of the bus.
- R3: Strobe vectors `clr_i`, `ld_i` and `inc_i` use bit 0 for the address register, 1 for the program counter, 2 for the data register, 3 for the accumulator, 4 for the instruction register, 5 for the scratch register and 6 for the output register. For each register, clear beats load and load beats increment.
- R4: An increment with no clear or load adds one modulo the register width. The program counter goes from 4095 to 0.
- R5: With `alu_op_i` = 0 (add), an accumulator load writes the low 16 bits of AC + DR, and the carry out goes to `e_o`.
- R6: An accumulator load with op 1 writes AC AND DR, and op 2 writes NOT AC. Op 3 writes DR, and op 4 writes the input register zero-extended. Ops 5 to 7 keep AC. Every op other than 0 leaves `e_o` unchanged.
- R7: The input register loads `inpr_data_i` when `inpr_ld_i` is high and keeps its value otherwise.
- R8: While `rst_ni` is low, every register and `e_o` read zero.
- R9: A register with no strobe holds its value. A register may load the value it is driving in the same cycle, keeping it, while other registers load the same value.
- R10: `e_clr_i` clears `e_o` and takes priority over a carry capture in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 3 | Bus source select |
| ld_i | input | 7 | Per-register load strobes |
| inc_i | input | 7 | Per-register increment strobes |
| clr_i | input | 7 | Per-register clear strobes |
| alu_op_i | input | 3 | Arithmetic/logic operation for accumulator loads |
| e_clr_i | input | 1 | Clear the carry flag |
| inpr_ld_i | input | 1 | Load the input register |
| inpr_data_i | input | 8 | Data for the input register |
| mem_rdata_i | input | 16 | Memory read data, bus source 7 |
| bus_o | output | 16 | Bus value, also the memory write data |
| ar_o | output | 12 | Address register, also the memory address |
| pc_o | output | 12 | Program counter |
| dr_o | output | 16 | Data register |
| ac_o | output | 16 | Accumulator |
| ir_o | output | 16 | Instruction register |
| tr_o | output | 16 | Scratch register |
| outr_o | output | 16 | Output register |
| inpr_o | output | 8 | Input register |
| e_o | output | 1 | Carry flag |

## Verification
The hardest cases to reach are the ones that need several strobes or sources in the same cycle. These are clear, load and increment together on one register; an add whose carry collides with a flag clear; and a register loading its own bus value. Each needs operands staged ahead of time. The stimulus first pulls chosen words from the memory port into the data register, so that the add carries, the program counter can be set to 4095, and the collision cycles see known values. A reference model in the bench follows each cycle. Its expected bus value and register contents are queued and then compared after the edge.

// File: rtl/acc_bus_pkg.sv
package acc_bus_pkg;
  localparam int SEL_W = 3;
  localparam int OP_W  = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_NONE = 3'd0,
    SEL_AR   = 3'd1,
    SEL_PC   = 3'd2,
    SEL_DR   = 3'd3,
    SEL_AC   = 3'd4,
    SEL_IR   = 3'd5,
    SEL_TR   = 3'd6,
    SEL_MEM  = 3'd7
  } bus_sel_e;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 3'd0,
    OP_AND = 3'd1,
    OP_CMA = 3'd2,
    OP_XDR = 3'd3,
    OP_XIN = 3'd4
  } alu_op_e;

  // strobe bit positions
  localparam int RI_AR   = 0;
  localparam int RI_PC   = 1;
  localparam int RI_DR   = 2;
  localparam int RI_AC   = 3;
  localparam int RI_IR   = 4;
  localparam int RI_TR   = 5;
  localparam int RI_OUTR = 6;
  localparam int NUM_REGS = 7;
endpackage

// File: rtl/acc_reg_cell.sv
module acc_reg_cell #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         ld_i,
  input  logic         inc_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_q <= '0;
    else if (clr_i)  q_q <= '0;
    else if (ld_i)   q_q <= d_i;
    else if (inc_i)  q_q <= q_q + W'(1);
  end

  assign q_o = q_q;

  AST_CLR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (q_o == '0)); // R3
  AST_LD_BEATS_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && ld_i) |=> (q_o == $past(d_i))); // R3
  AST_INC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !ld_i && inc_i) |=> (q_o == $past(q_o) + W'(1))); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !ld_i && !inc_i) |=> $stable(q_o)); // R9
endmodule

// File: rtl/acc_bus_mux.sv
module acc_bus_mux #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input  logic [2:0]        sel_i,
  input  logic [ADDR_W-1:0] ar_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [DATA_W-1:0] dr_i,
  input  logic [DATA_W-1:0] ac_i,
  input  logic [DATA_W-1:0] ir_i,
  input  logic [DATA_W-1:0] tr_i,
  input  logic [DATA_W-1:0] mem_i,
  output logic [DATA_W-1:0] bus_o
);
  import acc_bus_pkg::*;
  localparam int PAD_W = DATA_W - ADDR_W;

  always_comb begin
    unique case (bus_sel_e'(sel_i))
      SEL_AR:  bus_o = {{PAD_W{1'b0}}, ar_i};
      SEL_PC:  bus_o = {{PAD_W{1'b0}}, pc_i};
      SEL_DR:  bus_o = dr_i;
      SEL_AC:  bus_o = ac_i;
      SEL_IR:  bus_o = ir_i;
      SEL_TR:  bus_o = tr_i;
      SEL_MEM: bus_o = mem_i;
      default: bus_o = '0;
    endcase
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int DATA_W = 16,
  parameter int IN_W   = 8
) (
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] ac_i,
  input  logic [DATA_W-1:0] dr_i,
  input  logic [IN_W-1:0]   inpr_i,
  output logic [DATA_W-1:0] res_o,
  output logic              carry_o
);
  import acc_bus_pkg::*;
  logic [DATA_W:0] sum;

  assign sum     = {1'b0, ac_i} + {1'b0, dr_i};
  assign carry_o = sum[DATA_W];

  always_comb begin
    unique case (op_i)
      OP_ADD:  res_o = sum[DATA_W-1:0];
      OP_AND:  res_o = ac_i & dr_i;
      OP_CMA:  res_o = ~ac_i;
      OP_XDR:  res_o = dr_i;
      OP_XIN:  res_o = {{(DATA_W-IN_W){1'b0}}, inpr_i};
      default: res_o = ac_i;
    endcase
  end
endmodule

// File: rtl/acc_bus_datapath.sv
module acc_bus_datapath #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12,
  parameter int IN_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        sel_i,
  input  logic [6:0]        ld_i,
  input  logic [6:0]        inc_i,
  input  logic [6:0]        clr_i,
  input  logic [2:0]        alu_op_i,
  input  logic              e_clr_i,
  input  logic              inpr_ld_i,
  input  logic [IN_W-1:0]   inpr_data_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [DATA_W-1:0] bus_o,
  output logic [ADDR_W-1:0] ar_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [DATA_W-1:0] dr_o,
  output logic [DATA_W-1:0] ac_o,
  output logic [DATA_W-1:0] ir_o,
  output logic [DATA_W-1:0] tr_o,
  output logic [DATA_W-1:0] outr_o,
  output logic [IN_W-1:0]   inpr_o,
  output logic              e_o
);
  import acc_bus_pkg::*;

  localparam int NUM_NARROW = 2;
  localparam int NUM_WIDE   = 4;
  localparam int NARROW_IDX [NUM_NARROW] = '{RI_AR, RI_PC};
  localparam int WIDE_IDX   [NUM_WIDE]   = '{RI_DR, RI_IR, RI_TR, RI_OUTR};

  logic [DATA_W-1:0] bus;
  logic [ADDR_W-1:0] narrow_q [NUM_NARROW];
  logic [DATA_W-1:0] wide_q   [NUM_WIDE];
  logic [DATA_W-1:0] alu_res;
  logic              alu_carry;
  logic              e_q;
  logic              add_capture;

  // address register and program counter: low bus bits only
  for (genvar g = 0; g < NUM_NARROW; g++) begin : g_narrow
    acc_reg_cell #(.W(ADDR_W)) u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr_i[NARROW_IDX[g]]),
      .ld_i   (ld_i[NARROW_IDX[g]]),
      .inc_i  (inc_i[NARROW_IDX[g]]),
      .d_i    (bus[ADDR_W-1:0]),
      .q_o    (narrow_q[g])
    );
  end

  for (genvar g = 0; g < NUM_WIDE; g++) begin : g_wide
    acc_reg_cell #(.W(DATA_W)) u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr_i[WIDE_IDX[g]]),
      .ld_i   (ld_i[WIDE_IDX[g]]),
      .inc_i  (inc_i[WIDE_IDX[g]]),
      .d_i    (bus),
      .q_o    (wide_q[g])
    );
  end

  // accumulator loads from the ALU, not the bus
  acc_reg_cell #(.W(DATA_W)) u_ac (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_i[RI_AC]),
    .ld_i   (ld_i[RI_AC]),
    .inc_i  (inc_i[RI_AC]),
    .d_i    (alu_res),
    .q_o    (ac_o)
  );

  acc_reg_cell #(.W(IN_W)) u_inpr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (1'b0),
    .ld_i   (inpr_ld_i),
    .inc_i  (1'b0),
    .d_i    (inpr_data_i),
    .q_o    (inpr_o)
  );

  acc_alu #(.DATA_W(DATA_W), .IN_W(IN_W)) u_alu (
    .op_i    (alu_op_i),
    .ac_i    (ac_o),
    .dr_i    (wide_q[0]),
    .inpr_i  (inpr_o),
    .res_o   (alu_res),
    .carry_o (alu_carry)
  );

  acc_bus_mux #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mux (
    .sel_i (sel_i),
    .ar_i  (narrow_q[0]),
    .pc_i  (narrow_q[1]),
    .dr_i  (wide_q[0]),
    .ac_i  (ac_o),
    .ir_i  (wide_q[1]),
    .tr_i  (wide_q[2]),
    .mem_i (mem_rdata_i),
    .bus_o (bus)
  );

  // carry capture only when AC really takes an add result
  assign add_capture = ld_i[RI_AC] && !clr_i[RI_AC] && (alu_op_i == OP_ADD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          e_q <= 1'b0;
    else if (e_clr_i)     e_q <= 1'b0;
    else if (add_capture) e_q <= alu_carry;
  end

  assign bus_o  = bus;
  assign ar_o   = narrow_q[0];
  assign pc_o   = narrow_q[1];
  assign dr_o   = wide_q[0];
  assign ir_o   = wide_q[1];
  assign tr_o   = wide_q[2];
  assign outr_o = wide_q[3];
  assign e_o    = e_q;

  AST_SEL_NONE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == SEL_NONE) |-> (bus_o == '0)); // R1
  AST_ADDR_ZEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == SEL_AR || sel_i == SEL_PC) |-> (bus_o[DATA_W-1:ADDR_W] == '0)); // R2
  AST_ADD_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_i[RI_AC] && !clr_i[RI_AC] && !e_clr_i && alu_op_i == OP_ADD)
      |=> ({e_o, ac_o} == $past({1'b0, ac_o}) + $past({1'b0, dr_o}))); // R5
  AST_E_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!e_clr_i && !(ld_i[RI_AC] && alu_op_i == OP_ADD)) |=> $stable(e_o)); // R6
  AST_E_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    e_clr_i |=> !e_o); // R10
  AST_INPR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inpr_ld_i |=> $stable(inpr_o)); // R7
endmodule

// File: tb/acc_bus_datapath_test.sv
`timescale 1ns/1ps
module acc_bus_datapath_test;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic [2:0]  sel;
  logic [6:0]  ld, inc, clr;
  logic [2:0]  op;
  logic        e_clr, inpr_ld;
  logic [7:0]  inpr_data;
  logic [15:0] mem_rdata;
  logic [15:0] bus, dr, ac, ir, tr, outr;
  logic [11:0] ar, pc;
  logic [7:0]  inpr;
  logic        e;

  always #4 clk = ~clk;

  acc_bus_datapath uut (
    .clk_i(clk), .rst_ni(rst_ni), .sel_i(sel), .ld_i(ld), .inc_i(inc), .clr_i(clr),
    .alu_op_i(op), .e_clr_i(e_clr), .inpr_ld_i(inpr_ld), .inpr_data_i(inpr_data),
    .mem_rdata_i(mem_rdata), .bus_o(bus), .ar_o(ar), .pc_o(pc), .dr_o(dr), .ac_o(ac),
    .ir_o(ir), .tr_o(tr), .outr_o(outr), .inpr_o(inpr), .e_o(e)
  );

  localparam logic [6:0] M_AR = 7'h01, M_PC = 7'h02, M_DR = 7'h04, M_AC = 7'h08,
                         M_IR = 7'h10, M_TR = 7'h20, M_OUT = 7'h40;

  typedef struct {
    logic [15:0] bus;
    logic [11:0] ar, pc;
    logic [15:0] dr, ac, ir, tr, outr;
    logic [7:0]  inpr;
    logic        e;
    string       tag;
  } item_t;

  item_t sb[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [11:0] m_ar = '0, m_pc = '0;
  logic [15:0] m_dr = '0, m_ac = '0, m_ir = '0, m_tr = '0, m_outr = '0;
  logic [7:0]  m_inpr = '0;
  logic        m_e = 1'b0;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] m_bus(input logic [2:0] s);
    case (s)
      3'd1: return {4'h0, m_ar};
      3'd2: return {4'h0, m_pc};
      3'd3: return m_dr;
      3'd4: return m_ac;
      3'd5: return m_ir;
      3'd6: return m_tr;
      3'd7: return mem_rdata;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [15:0] upd16(input logic [15:0] q, input logic c, input logic l,
                                        input logic i, input logic [15:0] d);
    if (c) return 16'h0;
    if (l) return d;
    if (i) return q + 16'd1;
    return q;
  endfunction

  function automatic logic [11:0] upd12(input logic [11:0] q, input logic c, input logic l,
                                        input logic i, input logic [11:0] d);
    if (c) return 12'h0;
    if (l) return d;
    if (i) return q + 12'd1;
    return q;
  endfunction

  task automatic step(input logic [2:0] s, input logic [6:0] l, input logic [6:0] i,
                      input logic [6:0] c, input logic [2:0] o, input logic ec,
                      input logic il, input logic [7:0] id, input logic [15:0] mem,
                      input string tag);
    item_t it;
    logic [15:0] b, alu;
    logic [16:0] sum;
    @(negedge clk);
    sel = s; ld = l; inc = i; clr = c; op = o; e_clr = ec;
    inpr_ld = il; inpr_data = id; mem_rdata = mem;
    b   = m_bus(s);
    sum = {1'b0, m_ac} + {1'b0, m_dr};
    case (o)
      3'd0: alu = sum[15:0];
      3'd1: alu = m_ac & m_dr;
      3'd2: alu = ~m_ac;
      3'd3: alu = m_dr;
      3'd4: alu = {8'h00, m_inpr};
      default: alu = m_ac;
    endcase
    if (ec) m_e = 1'b0;
    else if (l[3] && !c[3] && o == 3'd0) m_e = sum[16];
    m_ar   = upd12(m_ar, c[0], l[0], i[0], b[11:0]);
    m_pc   = upd12(m_pc, c[1], l[1], i[1], b[11:0]);
    m_dr   = upd16(m_dr, c[2], l[2], i[2], b);
    m_ac   = upd16(m_ac, c[3], l[3], i[3], alu);
    m_ir   = upd16(m_ir, c[4], l[4], i[4], b);
    m_tr   = upd16(m_tr, c[5], l[5], i[5], b);
    m_outr = upd16(m_outr, c[6], l[6], i[6], b);
    if (il) m_inpr = id;
    it.bus = b; it.ar = m_ar; it.pc = m_pc; it.dr = m_dr; it.ac = m_ac; it.ir = m_ir;
    it.tr = m_tr; it.outr = m_outr; it.inpr = m_inpr; it.e = m_e; it.tag = tag;
    sb.push_back(it);
  endtask

  // monitor: bus mid-cycle, registers after the edge
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      #2;
      if (sb.size() > 0) begin
        it = sb[0];
        chk(it.tag, "bus", 32'(bus), 32'(it.bus));
        @(posedge clk);
        #1;
        chk(it.tag, "ar", 32'(ar), 32'(it.ar));
        chk(it.tag, "pc", 32'(pc), 32'(it.pc));
        chk(it.tag, "dr", 32'(dr), 32'(it.dr));
        chk(it.tag, "ac", 32'(ac), 32'(it.ac));
        chk(it.tag, "ir", 32'(ir), 32'(it.ir));
        chk(it.tag, "tr", 32'(tr), 32'(it.tr));
        chk(it.tag, "outr", 32'(outr), 32'(it.outr));
        chk(it.tag, "inpr", 32'(inpr), 32'(it.inpr));
        chk(it.tag, "e", 32'(e), 32'(it.e));
        void'(sb.pop_front());
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; sel = '0; ld = '0; inc = '0; clr = '0; op = '0;
    e_clr = 1'b0; inpr_ld = 1'b0; inpr_data = '0; mem_rdata = '0;
    repeat (3) @(posedge clk);
    #1;
    // R8: reset state
    chk("R8", "ar", 32'(ar), 0);   chk("R8", "pc", 32'(pc), 0);
    chk("R8", "ac", 32'(ac), 0);   chk("R8", "dr", 32'(dr), 0);
    chk("R8", "outr", 32'(outr), 0); chk("R8", "inpr", 32'(inpr), 0);
    chk("R8", "e", 32'(e), 0);
    @(negedge clk);
    rst_ni = 1'b1;

    step(0, 0, 0, 0, 0, 0, 1, 8'hA5, 16'h0, "R7");
    step(7, M_DR, 0, 0, 0, 0, 0, 8'hA5, 16'h1234, "R1");
    step(3, M_AR | M_IR, 0, 0, 0, 0, 0, 8'hA5, 16'h0, "R2");
    step(1, M_TR, 0, 0, 0, 0, 0, 8'hA5, 16'h0, "R2");
    step(0, M_OUT, 0, 0, 0, 0, 0, 8'hA5, 16'hBEEF, "R1");
    step(0, M_AC, 0, 0, 3, 0, 0, 8'hA5, 16'h0, "R6");
    step(7, M_DR, 0, 0, 0, 0, 0, 8'hA5, 16'hF000, "R1");
    step(0, M_AC, 0, 0, 0, 0, 0, 8'hA5, 16'h0, "R5");
    step(0, M_AC, 0, 0, 1, 0, 0, 8'hA5, 16'h0, "R6");
    step(0, M_AC, 0, 0, 2, 0, 0, 8'hA5, 16'h0, "R6");
    step(0, M_AC, 0, 0, 4, 0, 0, 8'hA5, 16'h0, "R6");
    step(0, 0, 0, 0, 0, 1, 0, 8'hA5, 16'h0, "R10");
    step(7, M_DR, 0, 0, 0, 0, 0, 8'hA5, 16'h0001, "R1");
    step(0, M_AC, 0, 0, 0, 0, 0, 8'hA5, 16'h0, "R5");
    step(7, M_DR, 0, 0, 0, 0, 0, 8'hA5, 16'hFFFF, "R1");
    step(0, M_AC, 0, 0, 0, 0, 0, 8'hA5, 16'h0, "R5");
    step(0, M_AC, 0, 0, 0, 1, 0, 8'hA5, 16'h0, "R10");
    step(0, M_AC, 0, 0, 6, 0, 0, 8'hA5, 16'h0, "R6");
    step(3, M_AR, M_AR, M_AR, 0, 0, 0, 8'hA5, 16'h0, "R3");
    step(3, M_PC, M_PC, 0, 0, 0, 0, 8'hA5, 16'h0, "R3");
    step(0, 0, M_PC, 0, 0, 0, 0, 8'hA5, 16'h0, "R4");
    step(0, 0, M_PC, 0, 0, 0, 0, 8'hA5, 16'h0, "R4");
    step(0, 0, M_AC, 0, 0, 0, 0, 8'hA5, 16'h0, "R4");
    step(0, M_AC, M_AC, M_AC, 2, 0, 0, 8'hA5, 16'h0, "R3");
    step(5, M_IR | M_OUT, 0, 0, 0, 0, 0, 8'hA5, 16'h0, "R9");
    step(0, 0, 0, 0, 0, 0, 0, 8'h3C, 16'h0, "R7");
    step(2, 0, 0, 0, 0, 0, 0, 8'h3C, 16'h0, "R2");
    step(6, 0, 0, 0, 0, 0, 0, 8'h3C, 16'h0, "R1");
    step(4, 0, 0, 0, 0, 0, 0, 8'h3C, 16'h0, "R1");
    step(5, 0, 0, 0, 0, 0, 0, 8'h3C, 16'h0, "R1");
    step(0, 0, M_TR, 0, 0, 0, 0, 8'h3C, 16'h0, "R4");
    step(0, 0, 0, 0, 0, 0, 0, 8'h3C, 16'h0, "R9");

    @(negedge clk);
    sel = '0; ld = '0; inc = '0; clr = '0; e_clr = 1'b0; inpr_ld = 1'b0;
    while (sb.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    if (!done) begin
      done = 1;
      summary();
      $finish;
    end
  end
endmodule